// File: doc/BRIEF.md
# Page Buffer Column Pointer with Spare Region

This block keeps the column position for byte-serial transfers into or out of a page buffer. The buffer holds a main region of 512 bytes followed by a spare region of 16 bytes, so the flat index runs from 0 to 527. An address phase loads a starting column. Each data strobe after that moves the pointer on by one byte. The outputs are the flat buffer index, a flag that shows the pointer is in the spare region, a sticky end-of-page indication and a sticky protocol-error flag.

The pointer goes past main byte 511 into the spare region only when the active-low spare enable was low at the strobe taken at byte 510, which is two accesses ahead of the crossing. Otherwise the page ends at byte 511. A load with the read-spare start input set, and the spare enable low in that same cycle, places the pointer directly inside the spare region. Once in the spare region, the spare enable must stay low until the page ends. The command decoder drives the read-spare start input, and the buffer memory uses the index.

Top module: `page_col_ptr`

## Requirements
- R1: While rst_ni is low and right after it is released, index_o is 0 and in_spare_o, end_of_page_o and proto_err_o are all 0.
- R2: When load_i is high, the next cycle shows index_o = col_i and clears end_of_page_o and proto_err_o. This applies when start_spare_i is low, or when spare_n_i is high. load_i takes priority over strobe_i.
- R3: When the pointer is below 511 in the main region and end_of_page_o is low, each strobe_i raises index_o by exactly one in the next cycle. With no strobe, index_o holds.
- R4: When spare_n_i was high at the strobe taken at index 510, the strobe at 511 sets end_of_page_o and index_o stays at 511.
- R5: When spare_n_i was low at the strobe taken at index 510, the strobe at 511 moves index_o to 512 and sets in_spare_o.
- R6: spare_n_i is sampled only at index 510. Driving it low only while the pointer sits at 511 does not open the spare region, and the page ends at 511.
- R7: A load with start_spare_i high and spare_n_i low in the same cycle sets index_o = 512 + col_i[3:0] and in_spare_o = 1.
- R8: A strobe at index 527 sets end_of_page_o. While end_of_page_o is high, strobes leave index_o unchanged.
- R9: When spare_n_i is high in any cycle where in_spare_o is 1 and end_of_page_o is 0, proto_err_o is set in the next cycle. It stays set until the next load.
- R10: in_spare_o is 1 exactly when index_o is at least 512, and index_o never goes above 527.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load the starting column (address phase) |
| col_i | input | 9 | Starting column in the main region; the low 4 bits give the spare offset on a read-spare load |
| start_spare_i | input | 1 | On a load, begin in the spare region (read-spare command) |
| strobe_i | input | 1 | One data transfer; advance the pointer |
| spare_n_i | input | 1 | Spare enable, active low |
| index_o | output | 10 | Flat buffer index, 0 to 527 |
| in_spare_o | output | 1 | Pointer is in the spare region |
| end_of_page_o | output | 1 | Page exhausted; strobes are ignored |
| proto_err_o | output | 1 | Spare enable was released during spare access |

## Verification
Every output is registered. A load, a strobe or a change on spare_n_i therefore shows up after exactly one rising edge. The spare-entry decision is the exception: it depends on the spare enable value captured at the strobe two accesses earlier, at index 510. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each read lands one full edge after the stimulus that caused it. The late-enable case lowers spare_n_i only after index 510 has passed, and then checks at the ports that the crossing is still refused.

// File: rtl/page_col_pkg.sv
package page_col_pkg;
  localparam int unsigned DEF_MAIN_BYTES  = 512;
  localparam int unsigned DEF_SPARE_BYTES = 16;

  typedef enum logic {REGION_MAIN = 1'b0, REGION_SPARE = 1'b1} region_e;
endpackage

// File: rtl/page_col_arm.sv
// Captures the spare enable at the lead position and flags early release.
module page_col_arm #(
  parameter int unsigned MAIN_BYTES = 512,
  parameter int unsigned IDX_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             strobe_i,
  input  logic             spare_n_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic             in_spare_i,
  input  logic             eop_i,
  output logic             armed_o,
  output logic             err_o
);
  localparam logic [IDX_W-1:0] LEAD_POS = IDX_W'(MAIN_BYTES - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (load_i) begin
      armed_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (strobe_i && !eop_i && ptr_i == LEAD_POS) armed_o <= !spare_n_i;
      if (in_spare_i && !eop_i && spare_n_i) err_o <= 1'b1;
    end
  end

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !load_i |=> err_o);
  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(in_spare_i) && $past(spare_n_i));
endmodule

// File: rtl/page_col_counter.sv
// Column pointer over the flat main+spare index space.
module page_col_counter #(
  parameter int unsigned MAIN_BYTES  = 512,
  parameter int unsigned SPARE_BYTES = 16,
  parameter int unsigned IDX_W       = 10,
  parameter int unsigned COL_W       = 9,
  parameter int unsigned SOFF_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             load_spare_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             strobe_i,
  input  logic             armed_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             eop_o
);
  localparam logic [IDX_W-1:0] LAST_MAIN  = IDX_W'(MAIN_BYTES - 1);
  localparam logic [IDX_W-1:0] FIRST_SPR  = IDX_W'(MAIN_BYTES);
  localparam logic [IDX_W-1:0] LAST_ALL   = IDX_W'(MAIN_BYTES + SPARE_BYTES - 1);

  logic [IDX_W-1:0] load_val;

  always_comb begin
    if (load_spare_i) load_val = FIRST_SPR + IDX_W'(col_i[SOFF_W-1:0]);
    else              load_val = IDX_W'(col_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      eop_o <= 1'b0;
    end else if (load_i) begin
      ptr_o <= load_val;
      eop_o <= 1'b0;
    end else if (strobe_i && !eop_o) begin
      if (ptr_o == LAST_MAIN) begin
        if (armed_i) ptr_o <= FIRST_SPR;
        else         eop_o <= 1'b1;
      end else if (ptr_o == LAST_ALL) begin
        eop_o <= 1'b1;
      end else begin
        ptr_o <= ptr_o + 1'b1;
      end
    end
  end

  assert_hold_at_eop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o && !load_i |=> $stable(ptr_o));
  assert_step_main_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !load_i && !eop_o && ptr_o < LAST_MAIN |=> ptr_o == $past(ptr_o) + 1'b1);
  assert_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST_ALL);
endmodule

// File: rtl/page_col_ptr.sv
module page_col_ptr #(
  parameter int unsigned MAIN_BYTES  = page_col_pkg::DEF_MAIN_BYTES,
  parameter int unsigned SPARE_BYTES = page_col_pkg::DEF_SPARE_BYTES,
  localparam int unsigned IDX_W      = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int unsigned COL_W      = $clog2(MAIN_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             start_spare_i,
  input  logic             strobe_i,
  input  logic             spare_n_i,
  output logic [IDX_W-1:0] index_o,
  output logic             in_spare_o,
  output logic             end_of_page_o,
  output logic             proto_err_o
);
  import page_col_pkg::*;
  localparam int unsigned SOFF_W = $clog2(SPARE_BYTES);
  localparam logic [IDX_W-1:0] LAST_MAIN = IDX_W'(MAIN_BYTES - 1);

  logic    armed;
  logic    load_spare;
  region_e region;

  assign load_spare = start_spare_i && !spare_n_i;
  assign region     = (index_o >= IDX_W'(MAIN_BYTES)) ? REGION_SPARE : REGION_MAIN;
  assign in_spare_o = (region == REGION_SPARE);

  page_col_counter #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .IDX_W(IDX_W), .COL_W(COL_W), .SOFF_W(SOFF_W)
  ) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_spare_i(load_spare),
    .col_i(col_i), .strobe_i(strobe_i), .armed_i(armed),
    .ptr_o(index_o), .eop_o(end_of_page_o)
  );

  page_col_arm #(.MAIN_BYTES(MAIN_BYTES), .IDX_W(IDX_W)) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .strobe_i(strobe_i),
    .spare_n_i(spare_n_i), .ptr_i(index_o), .in_spare_i(in_spare_o),
    .eop_i(end_of_page_o), .armed_o(armed), .err_o(proto_err_o)
  );

  assert_spare_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_spare_o) && !$past(load_i) |-> $past(index_o) == LAST_MAIN);
  assert_refuse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !load_i && !end_of_page_o && index_o == LAST_MAIN && !armed
    |=> end_of_page_o && index_o == LAST_MAIN);
endmodule

// File: tb/page_col_ptr_bench.sv
`timescale 1ns/1ps
module page_col_ptr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0, start_spare = 1'b0, strobe = 1'b0, spare_n = 1'b1;
  logic [8:0] col = '0;
  logic [9:0] index;
  logic       in_spare, eop, perr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  page_col_ptr u_page_col_ptr (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .col_i(col),
    .start_spare_i(start_spare), .strobe_i(strobe), .spare_n_i(spare_n),
    .index_o(index), .in_spare_o(in_spare), .end_of_page_o(eop), .proto_err_o(perr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive on negedge, one posedge, sample at next negedge.
  task automatic do_load(int c, bit spr);
    load = 1'b1; col = 9'(c); start_spare = spr;
    @(negedge clk);
    load = 1'b0; start_spare = 1'b0;
  endtask

  task automatic do_strobe(int n);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      @(negedge clk);
    end
    strobe = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 index", index, 0); chk("R1 in_spare", in_spare, 0);
    chk("R1 eop", eop, 0);     chk("R1 err", perr, 0);
  endtask

  task automatic t_main_walk;
    spare_n = 1'b1;
    do_load(5, 1'b0);
    chk("R2 load col", index, 5);
    do_strobe(3);
    chk("R3 advance", index, 8);
    @(negedge clk);
    chk("R3 hold idle", index, 8);
    load = 1'b1; col = 9'd100; strobe = 1'b1;
    @(negedge clk);
    load = 1'b0; strobe = 1'b0;
    chk("R2 load priority", index, 100);
  endtask

  task automatic t_no_spare;
    spare_n = 1'b1;
    do_load(508, 1'b0);
    do_strobe(3);
    chk("R4 at 511", index, 511); chk("R4 eop before", eop, 0);
    do_strobe(1);
    chk("R4 eop", eop, 1); chk("R4 hold 511", index, 511);
    chk("R10 main flag", in_spare, 0);
    do_strobe(2);
    chk("R8 no advance", index, 511);
    do_load(20, 1'b0);
    chk("R2 eop cleared", eop, 0); chk("R2 index", index, 20);
  endtask

  task automatic t_spare_roll;
    spare_n = 1'b0;
    do_load(509, 1'b0);
    do_strobe(2);
    chk("R5 at 511", index, 511);
    do_strobe(1);
    chk("R5 index 512", index, 512); chk("R5 in_spare", in_spare, 1);
    do_strobe(15);
    chk("R8 at 527", index, 527); chk("R8 eop low", eop, 0);
    do_strobe(1);
    chk("R8 eop", eop, 1); chk("R8 hold", index, 527);
    do_strobe(3);
    chk("R8 still 527", index, 527);
    chk("R9 no err", perr, 0);
  endtask

  task automatic t_late_enable;
    spare_n = 1'b1;
    do_load(509, 1'b0);
    do_strobe(2);
    spare_n = 1'b0;
    do_strobe(1);
    chk("R6 eop", eop, 1); chk("R6 index", index, 511);
    chk("R6 in_spare", in_spare, 0);
  endtask

  task automatic t_read_spare;
    spare_n = 1'b0;
    do_load(3, 1'b1);
    chk("R7 index", index, 515); chk("R7 in_spare", in_spare, 1);
    do_strobe(2);
    chk("R10 spare step", index, 517);
    spare_n = 1'b1;
    do_load(3, 1'b1);
    chk("R2 spare refused", index, 3); chk("R10 main", in_spare, 0);
  endtask

  task automatic t_proto_err;
    spare_n = 1'b0;
    do_load(0, 1'b1);
    do_strobe(1);
    chk("R9 clear", perr, 0);
    spare_n = 1'b1;
    @(negedge clk);
    chk("R9 set", perr, 1);
    spare_n = 1'b0;
    @(negedge clk);
    chk("R9 sticky", perr, 1);
    do_load(7, 1'b0);
    chk("R2 err cleared", perr, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_walk();
    t_no_spare();
    t_spare_roll();
    t_late_enable();
    t_read_spare();
    t_proto_err();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule